// File: doc/BRIEF.md
# Decimation Conversion Duration Timer

This block decides when one conversion of a sigma-delta decimation chain is finished. It counts pulses of a sample-clock enable and fires a one-cycle done pulse on the enable that closes the conversion. The length it counts depends on the filter oversampling ratio, the integrator oversampling ratio, the filter order and the filter type (plain sinc or fast sinc). When the filter is bypassed, only the integrator ratio sets the length.

A start pulse opens a conversion. If the continuing-sequence flag is high when a conversion ends, the next conversion begins at once. If fast-continuous mode is also enabled, each of these later conversions is shortened, because the filter already holds valid data and needs no refill. The first conversion after a start is always full length. The length is computed and latched when a conversion is loaded, so configuration may change freely while a conversion runs. A synchronous abort drops the block back to idle.

Top module: `dct_conv_timer`

## Requirements
- R1: With `filt_sel_i`=0 (sinc), `fosr_m1_i`>0 and a full-length conversion, the conversion lasts F*(I-1+N)+N enables. F=`fosr_m1_i`+1, I=`iosr_m1_i`+1, and N=`order_i` is in the range 1..5.
- R2: With `filt_sel_i`=1 (fast sinc), `fosr_m1_i`>0 and a full-length conversion, the conversion lasts F*(I+3)+2 enables, whatever `order_i` is.
- R3: A conversion that is reloaded at a done while `cont_i`=1 and `fast_cont_i`=1 lasts F*I enables.
- R4: A conversion opened by `start_i` is always full length (R1/R2/R5), even when `fast_cont_i`=1.
- R5: With `fosr_m1_i`=0 (filter bypassed), every conversion lasts I enables, for either filter type.
- R6: The length is latched when a conversion is loaded. Configuration changes during a conversion do not change its length. Cycles without an enable leave the count unchanged.
- R7: `done_o` is high for exactly the cycle of the last counted enable. It is only high while `busy_o`=1 and `smp_en_i`=1. Enables in the start cycle are not counted.
- R8: `abort_i` forces `busy_o` low from the next cycle and suppresses `done_o`, even on the last enable. Abort takes priority over start.
- R9: A `start_i` pulse while `busy_o`=1 is ignored. The running conversion keeps its length and configuration.
- R10: At a done with `cont_i`=1, `busy_o` stays high and a new conversion begins. Without `cont_i`, `busy_o` is low from the next cycle.
- R11: After reset, `busy_o`=0 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Sample-clock enable, one pulse per input sample |
| fosr_m1_i | input | 10 | Filter oversampling ratio minus one (0 = bypass) |
| iosr_m1_i | input | 10 | Integrator oversampling ratio minus one |
| order_i | input | 3 | Sinc filter order, 1..5 |
| filt_sel_i | input | 1 | 0 = sinc, 1 = fast sinc |
| fast_cont_i | input | 1 | Shorten continued conversions |
| cont_i | input | 1 | Continue with a new conversion at done |
| start_i | input | 1 | Start pulse, ignored while busy |
| abort_i | input | 1 | Synchronous abort |
| done_o | output | 1 | Conversion-done pulse |
| busy_o | output | 1 | Conversion in progress |

## Verification
The bench aims at these corner cases:
- **Fast-continuous sequence.** A design that shortened the opening conversion would end it after F*I enables instead of the full length.
- **Bypass.** A design that missed the bypass case would apply the filter-order terms and count far too long.
- **Mid-conversion changes.** Changing the configuration or pulsing start during a conversion would alter the count if the length were not latched.
- **Abort on the final enable.** An abort that did not take priority would still emit a done pulse.
- **Gapped enables.** Random gaps in the enable stream catch a design that counts clock cycles instead of enables.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic {
    FILT_SINC     = 1'b0,
    FILT_FASTSINC = 1'b1
  } filt_e;

  localparam int unsigned FASTSINC_TAIL  = 4;
  localparam int unsigned FASTSINC_CONST = 2;
endpackage

// File: rtl/dct_len_calc.sv
module dct_len_calc
  import dct_pkg::*;
#(
  parameter int unsigned OSR_W = 10,
  parameter int unsigned ORD_W = 3,
  parameter int unsigned CNT_W = 2 * (OSR_W + 1) + 1
) (
  input  logic [OSR_W-1:0] fosr_m1_i,
  input  logic [OSR_W-1:0] iosr_m1_i,
  input  logic [ORD_W-1:0] order_i,
  input  filt_e            filt_i,
  input  logic             short_i,
  output logic [CNT_W-1:0] len_o
);
  logic [CNT_W-1:0] f_w, i_w, tail_w, const_w, span_w;
  logic             bypass;

  always_comb begin
    f_w    = CNT_W'(fosr_m1_i) + CNT_W'(1);
    i_w    = CNT_W'(iosr_m1_i) + CNT_W'(1);
    bypass = (fosr_m1_i == '0);
    if (filt_i == FILT_FASTSINC) begin
      tail_w  = CNT_W'(FASTSINC_TAIL);
      const_w = CNT_W'(FASTSINC_CONST);
    end else begin
      tail_w  = CNT_W'(order_i);
      const_w = CNT_W'(order_i);
    end
    span_w = CNT_W'(iosr_m1_i) + tail_w;
    if (bypass)       len_o = i_w;
    else if (short_i) len_o = f_w * i_w;
    else              len_o = f_w * span_w + const_w;
  end
endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int unsigned CNT_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dct_seq_ctrl.sv
module dct_seq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_en_i,
  input  logic start_i,
  input  logic abort_i,
  input  logic cont_i,
  input  logic fast_cont_i,
  input  logic last_i,
  output logic load_o,
  output logic short_o,
  output logic dec_o,
  output logic done_o,
  output logic busy_o
);
  logic busy_q, busy_d, start_acc, reload;

  always_comb begin
    start_acc = start_i && !busy_q && !abort_i;
    done_o    = busy_q && smp_en_i && last_i && !abort_i;
    reload    = done_o && cont_i;
    load_o    = start_acc || reload;
    short_o   = reload && fast_cont_i;   // first conversion after start stays full
    dec_o     = busy_q && smp_en_i;
    if (abort_i)             busy_d = 1'b0;
    else if (load_o)         busy_d = 1'b1;
    else if (done_o)         busy_d = 1'b0;
    else                     busy_d = busy_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_d;
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/dct_conv_timer.sv
module dct_conv_timer
  import dct_pkg::*;
#(
  parameter int unsigned OSR_W = 10,
  parameter int unsigned ORD_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_en_i,
  input  logic [OSR_W-1:0] fosr_m1_i,
  input  logic [OSR_W-1:0] iosr_m1_i,
  input  logic [ORD_W-1:0] order_i,
  input  logic             filt_sel_i,
  input  logic             fast_cont_i,
  input  logic             cont_i,
  input  logic             start_i,
  input  logic             abort_i,
  output logic             done_o,
  output logic             busy_o
);
  localparam int unsigned CNT_W = 2 * (OSR_W + 1) + 1;

  logic [CNT_W-1:0] len_w, cnt_w;
  logic             load_w, short_w, dec_w, last_w;
  filt_e            filt_w;

  assign filt_w = filt_e'(filt_sel_i);

  dct_len_calc #(.OSR_W(OSR_W), .ORD_W(ORD_W), .CNT_W(CNT_W)) u_len (
    .fosr_m1_i (fosr_m1_i),
    .iosr_m1_i (iosr_m1_i),
    .order_i   (order_i),
    .filt_i    (filt_w),
    .short_i   (short_w),
    .len_o     (len_w)
  );

  dct_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_en_i    (smp_en_i),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .cont_i      (cont_i),
    .fast_cont_i (fast_cont_i),
    .last_i      (last_w),
    .load_o      (load_w),
    .short_o     (short_w),
    .dec_o       (dec_w),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (abort_i),
    .load_i (load_w),
    .len_i  (len_w),
    .dec_i  (dec_w),
    .cnt_o  (cnt_w),
    .last_o (last_w)
  );
endmodule

// File: rtl/dct_conv_timer_chk.sv
module dct_conv_timer_chk #(
  parameter int unsigned CNT_W = 23
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             smp_en_i,
  input logic             start_i,
  input logic             abort_i,
  input logic             cont_i,
  input logic             done_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] cnt_i
);
  assert_done_qual_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (busy_o && smp_en_i));

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !busy_o);

  assert_abort_nodone_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> !done_o);

  assert_cont_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cont_i) |=> busy_o);

  assert_end_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cont_i) |=> !busy_o);

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !smp_en_i && !abort_i) |=> $stable(cnt_i));

  assert_start_ign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !abort_i && !done_o) |=> busy_o);

  assert_idle_nodone_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !done_o);
endmodule

bind dct_conv_timer dct_conv_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .smp_en_i (smp_en_i),
  .start_i  (start_i),
  .abort_i  (abort_i),
  .cont_i   (cont_i),
  .done_o   (done_o),
  .busy_o   (busy_o),
  .cnt_i    (cnt_w)
);

// File: tb/sim_dct_conv_timer.sv
module sim_dct_conv_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_en_i = 1'b0;
  logic [9:0] fosr_m1_i = '0;
  logic [9:0] iosr_m1_i = '0;
  logic [2:0] order_i = 3'd1;
  logic       filt_sel_i = 1'b0;
  logic       fast_cont_i = 1'b0;
  logic       cont_i = 1'b0;
  logic       start_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       done_o, busy_o;

  always #2 clk_i = ~clk_i;

  dct_conv_timer u0 (.*);

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  s_done, s_busy;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog R7 actual %0d expected <150000 cycles", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int ref_len(int fm, int im, int ord, bit fs, bit sh);
    int f = fm + 1;
    int i = im + 1;
    if (f == 1) return i;
    if (sh)     return f * i;
    if (fs)     return f * (i + 3) + 2;
    return f * (i - 1 + ord) + ord;
  endfunction

  task automatic chk(bit ok, string r, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic cyc(bit en);
    smp_en_i = en;
    #1;
    s_done = done_o;
    s_busy = busy_o;
    @(posedge clk_i);
    #1;
    start_i  = 1'b0;
    abort_i  = 1'b0;
    smp_en_i = 1'b0;
  endtask

  // counts enables up to and including the one carrying done
  task automatic meas(int exp, string r, int rate);
    int n = 0;
    int g = 0;
    bit seen = 0;
    while (!seen && g < 5000) begin
      bit en;
      en = (($urandom % 4) < rate);
      cyc(en);
      g++;
      if (en) n++;
      if (s_done) begin
        seen = 1;
        if (!en) chk(0, "R7 done without enable", 0, 1);
      end
    end
    chk(n == exp, r, n, exp);
  endtask

  task automatic set_cfg(int fm, int im, int ord, bit fs);
    fosr_m1_i  = 10'(fm);
    iosr_m1_i  = 10'(im);
    order_i    = 3'(ord);
    filt_sel_i = fs;
  endtask

  task automatic launch(int fm, int im, int ord, bit fs, bit fc, bit ct);
    set_cfg(fm, im, ord, fs);
    fast_cont_i = fc;
    cont_i      = ct;
    start_i     = 1'b1;
    cyc(1);  // enable in the start cycle is not counted (R7)
  endtask

  initial begin
    int e;
    int nd;
    void'($urandom(32'd1234));
    #1;
    cyc(1);
    chk(!s_done && !s_busy, "R11 reset idle", {s_busy, s_done}, 0);
    rst_ni = 1'b1;
    cyc(0);
    chk(!s_busy, "R11 idle after release", s_busy, 0);

    for (int o = 1; o <= 5; o++) begin
      launch(3, 4, o, 0, 0, 0);
      meas(ref_len(3, 4, o, 0, 0), "R1 sinc order length", 4);
    end
    launch(5, 2, 1, 1, 0, 0);
    meas(ref_len(5, 2, 1, 1, 0), "R2 fast sinc length", 4);
    launch(2, 6, 5, 1, 0, 0);
    meas(ref_len(2, 6, 5, 1, 0), "R2 fast sinc ignores order", 3);

    launch(0, 6, 5, 0, 0, 0);
    meas(7, "R5 bypass sinc", 4);
    launch(0, 3, 2, 1, 1, 0);
    meas(4, "R5 bypass fast sinc", 2);

    launch(3, 2, 3, 0, 1, 1);
    meas(ref_len(3, 2, 3, 0, 0), "R4 first fast-continuous conversion full", 4);
    meas(12, "R3 shortened second conversion", 4);
    meas(12, "R3 shortened third conversion", 3);
    cont_i = 1'b0;
    meas(12, "R3 shortened last conversion", 4);
    cyc(0);
    chk(!s_busy, "R10 idle after final done", s_busy, 0);

    launch(2, 1, 2, 0, 0, 1);
    meas(ref_len(2, 1, 2, 0, 0), "R10 normal continuous first", 4);
    chk(1, "R10 continue", 0, 0);
    cont_i = 1'b0;
    meas(ref_len(2, 1, 2, 0, 0), "R10 normal continuous stays full", 4);

    e = ref_len(4, 3, 2, 0, 0);
    launch(4, 3, 2, 0, 0, 0);
    for (int k = 0; k < 3; k++) cyc(1);
    set_cfg(1, 0, 5, 1);
    meas(e - 3, "R6 config change mid conversion", 4);

    e = ref_len(2, 3, 4, 0, 0);
    launch(2, 3, 4, 0, 0, 0);
    cyc(1); cyc(1);
    set_cfg(0, 0, 1, 0);
    start_i = 1'b1;
    meas(e - 2, "R9 start while busy ignored", 4);

    launch(3, 3, 3, 0, 0, 0);
    cyc(1); cyc(1);
    abort_i = 1'b1;
    cyc(1);
    chk(!s_done, "R8 no done on abort", s_done, 0);
    cyc(1);
    chk(!s_busy, "R8 idle after abort", s_busy, 1'b0);
    nd = 0;
    for (int k = 0; k < 100; k++) begin cyc(1); if (s_done) nd++; end
    chk(nd == 0, "R8 no done after abort", nd, 0);

    launch(0, 0, 1, 0, 0, 0);
    abort_i = 1'b1;
    cyc(1);
    chk(!s_done, "R8 abort beats last enable", s_done, 0);
    cyc(0);
    chk(!s_busy, "R8 idle after final-enable abort", s_busy, 0);

    set_cfg(1, 1, 1, 0);
    start_i = 1'b1;
    abort_i = 1'b1;
    cyc(1);
    cyc(0);
    chk(!s_busy, "R8 abort over start", s_busy, 0);

    for (int t = 0; t < 60; t++) begin
      int fm, im, ord, rate;
      bit fs, fc;
      fm = $urandom % 8; im = $urandom % 8; ord = 1 + $urandom % 5;
      fs = $urandom % 2; fc = $urandom % 2; rate = 1 + $urandom % 4;
      launch(fm, im, ord, fs, fc, 0);
      meas(ref_len(fm, im, ord, fs, 0), "R4 random single conversion", rate);
    end

    for (int t = 0; t < 10; t++) begin
      int fm, im, ord;
      bit fs, fc;
      fm = $urandom % 6; im = $urandom % 6; ord = 1 + $urandom % 5;
      fs = $urandom % 2; fc = $urandom % 2;
      launch(fm, im, ord, fs, fc, 1);
      meas(ref_len(fm, im, ord, fs, 0), "R4 random sequence first", 3);
      meas(ref_len(fm, im, ord, fs, fc), "R3 random sequence second", 3);
      cont_i = 1'b0;
      meas(ref_len(fm, im, ord, fs, fc), "R3 random sequence last", 4);
      cyc(0);
      chk(!s_busy, "R10 random sequence ends idle", s_busy, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule